// File: doc/BRIEF.md
# Booth-Recoded Sequential Signed Multiplier

This block multiplies two signed two's-complement operands of N bits each and returns their signed 2N-bit product. It performs one step per multiplier bit. A single working register holds three things: the running upper half, the multiplier in the lower half, and one guard bit below the multiplier. On each step, the lowest multiplier bit and the guard bit select whether the multiplicand is added to the upper half, subtracted from it, or left out. The whole register then shifts right by one place, and the sign bit is copied into the vacated top position.

A caller presents both operands with a one-cycle `start` while the unit is idle. After exactly N steps the unit raises `done_o` for one cycle. The product then stays on `product_o` until the next accepted start. The upper-half arithmetic is carried out one bit wider than the operands. This keeps a transient overflow (for example, subtracting the most negative multiplicand from zero) from corrupting the sign that the shift replicates.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, `done_o` is 0 and `product_o` is 0.
- R2: `done_o` goes high for exactly one cycle. It rises in the cycle that follows the Nth clock edge after the edge that accepted `start`. The unit is idle whenever `done_o` is high.
- R3: When `done_o` is high, `product_o` equals the signed product of the accepted operands, as a 2N-bit two's-complement value. This holds for every operand pair.
- R4: A `start` that arrives while a multiplication is in progress is ignored. The result is that of the operands accepted first.
- R5: While the unit is idle and `start` is low, `product_o` does not change.
- R6: Each step looks at the pair formed by the lowest bit of the lower half (left) and the guard bit (right). The pair 10 subtracts the multiplicand from the upper half. The pair 01 adds it. The pairs 00 and 11 leave the upper half unchanged. The shift follows in every case.
- R7: A `start` presented in the same cycle in which `done_o` is high is accepted, so operations can run back to back with no idle cycle.
- R8: The result is correct when either operand is the most negative N-bit value, including when both are. For N=4, -8 × -8 gives 64 and -8 × 7 gives -56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| product_o | output | 2N | Signed product (upper and lower halves of the working register) |
| done_o | output | 1 | One-cycle pulse when the product is valid |

## Verification
The bound checker watches several properties on every cycle:
- the single-cycle shape of the done pulse, and that it coincides with idle;
- that the done pulse follows the last step;
- that the step counter keeps advancing regardless of `start` while busy;
- that the product holds while idle;
- that a no-op recoding leaves the upper half untouched.

Correctness of the arithmetic itself can only be shown by the bench's scenarios. The bench compares every N=4 operand pair, including the most negative values, against a reference model. It also injects a stray `start` mid-run, issues back-to-back starts in the done cycle, and checks the exact latency of each result.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Operation chosen for one step by the bit pair (low multiplier bit, guard bit)
    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    // R6: 10 -> subtract, 01 -> add, 00 / 11 -> nothing
    function automatic booth_op_e booth_decode(input logic cur_bit, input logic right_bit);
        booth_op_e op;
        unique case ({cur_bit, right_bit})
            2'b10:   op = BOOTH_SUB;
            2'b01:   op = BOOTH_ADD;
            default: op = BOOTH_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      guard_bit,
    output booth_op_e op
);
    always_comb begin
        op = booth_decode(cur_bit, guard_bit);
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] upper,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N:0]   sum
);
    localparam int W = N + 1;

    logic [W-1:0] upper_ext;
    logic [W-1:0] mcand_ext;
    logic [W-1:0] addend;

    always_comb begin
        upper_ext = {upper[N-1], upper};
        mcand_ext = {mcand[N-1], mcand};
        unique case (op)
            BOOTH_ADD: addend = mcand_ext;
            BOOTH_SUB: addend = ~mcand_ext + W'(1);
            default:   addend = '0;
        endcase
        sum = upper_ext + addend;
    end
endmodule

// File: rtl/booth_shifter.sv
module booth_shifter #(
    parameter int N = 8
) (
    input  logic [N:0]   sum,
    input  logic [N-1:0] lower,
    output logic [N-1:0] nxt_upper,
    output logic [N-1:0] nxt_lower,
    output logic         nxt_guard
);
    // Arithmetic shift of the (N+1)-bit sum: its top N bits keep sum[N] as sign
    always_comb begin
        nxt_upper = sum[N:1];
        nxt_lower = {sum[0], lower[N-1:1]};
        nxt_guard = lower[0];
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = (N > 2) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          load_en,
    output logic          step_en,
    output logic          done,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    ctl_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CTL_IDLE: begin
                    if (start) begin
                        state_q <= CTL_RUN;
                        cnt_q   <= '0;
                    end
                end
                CTL_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= CTL_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q == CTL_RUN);
        load_en = (state_q == CTL_IDLE) && start;
        step_en = (state_q == CTL_RUN);
        done    = done_q;
        cnt     = cnt_q;
    end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] product_o,
    output logic           done_o
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;

    logic [N-1:0] upper_q, lower_q, mcand_q;
    logic         guard_q;

    logic          busy, load_en, step_en;
    logic [CW-1:0] cnt_w;
    booth_op_e     step_op;
    logic [N:0]    sum_w;
    logic [N-1:0]  nxt_upper, nxt_lower;
    logic          nxt_guard;

    booth_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .load_en(load_en), .step_en(step_en),
        .done(done_o), .cnt(cnt_w)
    );

    booth_recoder u_rec (
        .cur_bit(lower_q[0]), .guard_bit(guard_q), .op(step_op)
    );

    booth_addsub #(.N(N)) u_add (
        .upper(upper_q), .mcand(mcand_q), .op(step_op), .sum(sum_w)
    );

    booth_shifter #(.N(N)) u_shf (
        .sum(sum_w), .lower(lower_q),
        .nxt_upper(nxt_upper), .nxt_lower(nxt_lower), .nxt_guard(nxt_guard)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            lower_q <= '0;
            guard_q <= 1'b0;
            mcand_q <= '0;
        end else if (load_en) begin
            upper_q <= '0;
            lower_q <= mplier_i;
            guard_q <= 1'b0;
            mcand_q <= mcand_i;
        end else if (step_en) begin
            upper_q <= nxt_upper;
            lower_q <= nxt_lower;
            guard_q <= nxt_guard;
        end
    end

    assign product_o = {upper_q, lower_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk
    import booth_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = (N > 2) ? $clog2(N) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [CW-1:0]  cnt,
    input booth_op_e      op,
    input logic [N-1:0]   upper,
    input logic [N:0]     sum,
    input logic [2*N-1:0] product
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    // R2: done lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: done only while idle
    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: the final step is followed by done
    a_r2_last_step: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST) |=> done);

    // R4: while busy the step counter advances regardless of start
    a_r4_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> (busy && cnt == CW'($past(cnt) + CW'(1))));

    // R5: idle without start keeps the product
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    // R6: a no-op step passes the upper half through the adder unchanged
    a_r6_noop_step: assert property (@(posedge clk) disable iff (rst)
        (busy && op == BOOTH_HOLD) |-> (sum == {upper[N-1], upper}));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done_o),
    .cnt(cnt_w), .op(step_op), .upper(upper_q), .sum(sum_w), .product(product_o)
);

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
    localparam int N = 4;
    localparam int PW = 2 * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N-1:0] mcand = '0;
    logic [N-1:0] mplier = '0;
    logic [PW-1:0] product;
    logic done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [PW-1:0] exp;
        int            start_cyc;
    } item_t;
    item_t sb[$];

    booth_seq_mult #(.N(N)) uut (
        .clk(clk), .rst(rst), .start(start), .mcand_i(mcand),
        .mplier_i(mplier), .product_o(product), .done_o(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        int ia, ib;
        ia = int'($signed(a));
        ib = int'($signed(b));
        return PW'(ia * ib);
    endfunction

    // Driver: call at a negedge; returns at the negedge where done is seen high
    task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input bit stray);
        item_t it;
        it.a = a; it.b = b; it.exp = ref_mul(a, b); it.start_cyc = cyc;
        sb.push_back(it);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            // R4: stray start with different operands in mid-run
            @(negedge clk);
            mcand = ~a; mplier = b + 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                // R3 R6 R8: signed product of the accepted operands
                check(product == it.exp, "R3 R6 R8 product",
                      longint'($signed(product)), longint'($signed(it.exp)));
                // R2: latency from the accepting edge
                check((cyc - it.start_cyc) == N + 1, "R2 latency",
                      cyc - it.start_cyc, N + 1);
            end
        end
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [PW-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(product == '0, "R1 product in reset", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && product == '0, "R1 after reset", product, 0);

        // R8: most negative corner cases first
        issue(4'b1000, 4'b1000, 1'b0); @(negedge clk);
        issue(4'b1000, 4'b0111, 1'b0); @(negedge clk);
        issue(4'b0111, 4'b1000, 1'b0); @(negedge clk);

        // R5: hold while idle
        issue(4'b0011, 4'b1101, 1'b0);
        held = product;
        repeat (4) @(negedge clk);
        check(product == held, "R5 hold while idle", product, held);
        check(done == 1'b0, "R2 done cleared while idle", done, 0);

        // R4: stray start mid-run ignored
        issue(4'b0101, 4'b0110, 1'b1); @(negedge clk);
        issue(4'b1001, 4'b1011, 1'b1); @(negedge clk);

        // R7: back-to-back starts in the done cycle
        issue(4'b0010, 4'b0111, 1'b0);
        issue(4'b0010, 4'b1101, 1'b0);
        issue(4'b1111, 4'b1111, 1'b0);
        @(negedge clk);

        // R3: exhaustive pairs
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                issue(N'(i), N'(j), 1'b0);
                @(negedge clk);
            end
        end

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 all results returned", sb.size(), 0);
        finished = 1'b1;
        report();
    end
endmodule